// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is the bus unit that carries an 8-bit processor's external program and data accesses onto a multiplexed memory bus. The processor presents a request: direction, a flag marking an instruction fetch, a 16-bit address and 8 bits of write data. The controller then runs one bus cycle. It returns the read data together with a single-tick ready pulse. On the memory side, one 8-bit port carries the low address byte and then the data. A second port carries the high address byte. Three active-low strobes complete the bus: address latch, read and write.

The controller's clock `clk` runs at twice the system clock, so one tick is half a system-clock period. Every strobe edge can therefore sit on a whole or a half system clock. A bus cycle has four phases in a fixed order. The latch phase lasts three ticks with the latch strobe low. The address hold phase lasts one tick. The strobe phase lasts three ticks with the read or write strobe low. Recovery lasts two ticks. The shared port is split into separate out, enable and in signals, and the pad ring joins them.

A fetch-routing input decides where instruction fetches go. Held low, it sends fetches out to the bus. Held high, fetches belong to internal memory and this block ignores them. Data reads and writes always use the bus. After reset, the high address port shows the upper byte of the boot address 0040h.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: While reset is active and after it ends with no request, the latch, read and write strobes are high, the shared port is not driven, ready is low and the high address port shows 00h, the upper byte of boot address 0040h.
- R2: A bus cycle starts with the latch strobe low for exactly 3 ticks. During all 3 of those ticks, the shared port drives the low address byte.
- R3: The low address stays driven for 1 tick after the latch strobe rises. During every tick that the read strobe is low, the shared port is not driven.
- R4: The read strobe is low for exactly 3 ticks. The read data returned is the value present on the shared port input in the last tick of that strobe.
- R5: The write strobe is low for exactly 3 ticks. The write data is driven through the whole strobe and for 1 tick after it rises. In the tick after that, the port is released.
- R6: The high address byte is on its port from the first latch tick until at least 2 ticks after the read or write strobe rises.
- R7: When a read is flagged as a fetch and the routing input is high, no strobe moves and no ready is given. When the routing input is low, the same fetch runs a full external read cycle.
- R8: A read never lowers the write strobe, and a write never lowers the read strobe. The latch strobe is never low together with either of them.
- R9: A request presented while a bus cycle is in progress is ignored. It starts no second cycle and gives no second ready.
- R10: Ready is high for exactly one tick per bus cycle: the first tick after the read or write strobe rises. For reads, the returned data is valid in that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fetch_n | input | 1 | Low: instruction fetches go to the external bus |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_ready | output | 1 | One-tick completion pulse |
| rsp_rdata | output | 8 | Read data |
| bus_ad_o | output | 8 | Shared port output value (low address or data) |
| bus_ad_oe | output | 1 | Shared port drive enable |
| bus_ad_i | input | 8 | Shared port input value |
| bus_ahi | output | 8 | High address byte |
| bus_ale_n | output | 1 | Address latch strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong phase or a bad tick count shows at the strobe ports within one bus cycle. A strobe that is a tick too short or too long is seen at the tick it rises. A port enable that is wrong for the current phase shows in the same tick, as a shared port still driven during a read strobe or a write that loses its data tick. A stale address or data register shows as a wrong latched address or wrong read data, and the bench's address-derived memory model catches it at the ready tick. A sequencer that fails to return to idle shows as a missing or repeated ready within the next ten ticks.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_RECV = 3'd4
  } ebc_phase_e;
endpackage

// File: rtl/ebc_rst_sync.sv
module ebc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ebc_phase_seq.sv
module ebc_phase_seq
  import ebc_pkg::*;
#(
  parameter int ALE_T = 3,
  parameter int HLD_T = 1,
  parameter int STB_T = 3,
  parameter int REC_T = 2,
  parameter int CW    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output ebc_phase_e      phase,
  output logic            last,
  output logic [CW-1:0]   cnt
);
  ebc_phase_e  ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    last  = (cnt_q == '0);
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d  = PH_ADDR;
        cnt_d = CW'(ALE_T - 1);
      end
      PH_ADDR: if (last) begin
        ph_d  = PH_HOLD;
        cnt_d = CW'(HLD_T - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (last) begin
        ph_d  = PH_STRB;
        cnt_d = CW'(STB_T - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_STRB: if (last) begin
        ph_d  = PH_RECV;
        cnt_d = CW'(REC_T - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_RECV: if (last) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end else cnt_d = cnt_q - 1'b1;
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          REC_T     = 2,
  parameter int          WDH_T     = 1,
  parameter int          CW        = 2,
  parameter logic [15:0] BOOT_ADDR = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  ebc_phase_e       phase,
  input  logic             last,
  input  logic [CW-1:0]    cnt,
  input  logic [DW-1:0]    bus_ad_i,
  output logic [DW-1:0]    bus_ad_o,
  output logic             bus_ad_oe,
  output logic [AW-DW-1:0] bus_ahi,
  output logic             bus_ale_n,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata
);
  localparam int HW = AW - DW;
  localparam logic [CW-1:0] WH_LIM = CW'(REC_T - 1 - WDH_T);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rdata_q, rdata_d;
  logic          we_q, rdy_q, rdy_d;
  logic          in_addr, in_strb, in_whold;

  always_comb begin
    in_addr  = (phase == PH_ADDR) || (phase == PH_HOLD);
    in_strb  = (phase == PH_STRB);
    in_whold = (phase == PH_RECV) && we_q && (cnt > WH_LIM);
    rdy_d    = in_strb && last;
    rdata_d  = (rdy_d && !we_q) ? bus_ad_i : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= AW'(BOOT_ADDR);
      wd_q   <= '0;
      we_q   <= 1'b0;
    end else if (start) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
      we_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q   <= rdy_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ad_oe = in_addr || (we_q && in_strb) || in_whold;
  assign bus_ad_o  = in_addr ? addr_q[DW-1:0] : wd_q;
  assign bus_ahi   = addr_q[AW-1:AW-HW];
  assign bus_ale_n = !(phase == PH_ADDR);
  assign bus_rd_n  = !(in_strb && !we_q);
  assign bus_wr_n  = !(in_strb && we_q);
  assign rsp_ready = rdy_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          ALE_T     = 3,
  parameter int          HLD_T     = 1,
  parameter int          STB_T     = 3,
  parameter int          REC_T     = 2,
  parameter int          WDH_T     = 1,
  parameter logic [15:0] BOOT_ADDR = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_fetch_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic [DW-1:0]    bus_ad_o,
  output logic             bus_ad_oe,
  input  logic [DW-1:0]    bus_ad_i,
  output logic [AW-DW-1:0] bus_ahi,
  output logic             bus_ale_n,
  output logic             bus_rd_n,
  output logic             bus_wr_n
);
  localparam int MAXT_A = (ALE_T > STB_T) ? ALE_T : STB_T;
  localparam int MAXT_B = (HLD_T > REC_T) ? HLD_T : REC_T;
  localparam int MAXT   = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B;
  localparam int CW     = (MAXT > 1) ? $clog2(MAXT) : 1;

  logic          rst_sync_n;
  ebc_phase_e    phase;
  logic          last;
  logic [CW-1:0] cnt;
  logic          goes_out, start;

  always_comb begin
    goes_out = req_write || !req_fetch || !ext_fetch_n;
    start    = req_valid && (phase == PH_IDLE) && goes_out;
  end

  ebc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ebc_phase_seq #(
    .ALE_T (ALE_T), .HLD_T (HLD_T), .STB_T (STB_T), .REC_T (REC_T), .CW (CW)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .phase (phase),
    .last  (last),
    .cnt   (cnt)
  );

  ebc_datapath #(
    .AW (AW), .DW (DW), .REC_T (REC_T), .WDH_T (WDH_T), .CW (CW),
    .BOOT_ADDR (BOOT_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phase     (phase),
    .last      (last),
    .cnt       (cnt),
    .bus_ad_i  (bus_ad_i),
    .bus_ad_o  (bus_ad_o),
    .bus_ad_oe (bus_ad_oe),
    .bus_ahi   (bus_ahi),
    .bus_ale_n (bus_ale_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/ebc_bus_ctrl_chk.sv
module ebc_bus_ctrl_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rsp_ready,
  input logic          bus_ad_oe,
  input logic [HW-1:0] bus_ahi,
  input logic          bus_ale_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n
);
  // R3
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R8
  ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ale_n |-> (bus_rd_n && bus_wr_n));

  // R2
  ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ale_n |-> bus_ad_oe);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ale_n) |-> bus_ad_oe);

  // R4
  rd_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |=> !bus_rd_n);

  // R5
  wr_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |=> !bus_wr_n);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R10
  ready_after_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> rsp_ready);

  // R6
  ahi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |=> $stable(bus_ahi));
endmodule

bind ebc_bus_ctrl ebc_bus_ctrl_chk #(.HW(AW - DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_ready (rsp_ready),
  .bus_ad_oe (bus_ad_oe),
  .bus_ahi   (bus_ahi),
  .bus_ale_n (bus_ale_n),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n)
);

// File: tb/ebc_bus_ctrl_tb.sv
module ebc_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_fetch_n, req_valid, req_write, req_fetch;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_ready;
  logic [7:0]  rsp_rdata, bus_ad_o, bus_ad_i, bus_ahi;
  logic        bus_ad_oe, bus_ale_n, bus_rd_n, bus_wr_n;
  logic [7:0]  lat_lo;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return 8'(a[7:0] * 7 + a[15:8] * 13 + 3);
  endfunction

  // memory model: drives the shared port only while the read strobe is low
  assign bus_ad_i = !bus_rd_n ? mem_f({bus_ahi, lat_lo}) : 8'hEE;

  ebc_bus_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .ext_fetch_n (ext_fetch_n),
    .req_valid (req_valid), .req_write (req_write), .req_fetch (req_fetch),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
    .bus_ad_o (bus_ad_o), .bus_ad_oe (bus_ad_oe), .bus_ad_i (bus_ad_i),
    .bus_ahi (bus_ahi), .bus_ale_n (bus_ale_n),
    .bus_rd_n (bus_rd_n), .bus_wr_n (bus_wr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; all bus behaviour observed tick by tick at the falling edge
  task automatic run_cycle(input bit we, input bit fetch, input bit sel_n,
                           input logic [15:0] a, input logic [7:0] wd,
                           input bit expect_bus, input bit busy_req);
    int ale_cnt = 0, ale_rises = 0, rd_cnt = 0, wr_cnt = 0, rdy_cnt = 0;
    bit ale_bad = 0, hold_bad = 0, flt_bad = 0, wdat_bad = 0, ahi_bad = 0;
    bit wrel_bad = 0, rd_on_wr = 0, wr_on_rd = 0, rdy_pos_bad = 0;
    int age = -1;
    logic [7:0] got = 8'h00;
    bit p_ale = 1, p_rd = 1, p_wr = 1;
    @(negedge clk);
    ext_fetch_n = sel_n; req_write = we; req_fetch = fetch;
    req_addr = a; req_wdata = wd; req_valid = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (t == 0) req_valid = 1'b0;
      if (busy_req && t == 3) begin
        req_valid = 1'b1; req_addr = ~a; req_write = ~we; req_fetch = 1'b0;
      end
      if (busy_req && t == 4) req_valid = 1'b0;
      if (!bus_ale_n) begin
        ale_cnt++;
        if (!(bus_ad_oe && bus_ad_o == a[7:0])) ale_bad = 1;
      end
      if (!p_ale && bus_ale_n) begin
        ale_rises++;
        lat_lo = bus_ad_o;
        if (!(bus_ad_oe && bus_ad_o == a[7:0])) hold_bad = 1;
      end
      if (!bus_rd_n) begin rd_cnt++; if (bus_ad_oe) flt_bad = 1; if (we) rd_on_wr = 1; end
      if (!bus_wr_n) begin
        wr_cnt++;
        if (!we) wr_on_rd = 1;
        if (!(bus_ad_oe && bus_ad_o == wd)) wdat_bad = 1;
      end
      if ((!p_rd && bus_rd_n) || (!p_wr && bus_wr_n)) begin
        age = 0;
        if (!rsp_ready) rdy_pos_bad = 1;
        if (!p_wr && !(bus_ad_oe && bus_ad_o == wd)) wrel_bad = 1;
      end else if (age >= 0) age++;
      if (age == 1 && we && bus_ad_oe) wrel_bad = 1;
      if ((!bus_ale_n || !bus_rd_n || !bus_wr_n || age == 0 || age == 1)
          && bus_ahi != a[15:8]) ahi_bad = 1;
      if (rsp_ready) begin rdy_cnt++; got = rsp_rdata; end
      p_ale = bus_ale_n; p_rd = bus_rd_n; p_wr = bus_wr_n;
    end
    if (!expect_bus) begin
      // R7 internal fetch: no strobe and no ready
      chk(ale_cnt == 0 && rd_cnt == 0 && wr_cnt == 0, "R7 strobes", ale_cnt + rd_cnt + wr_cnt, 0);
      chk(rdy_cnt == 0, "R7 ready", rdy_cnt, 0);
      return;
    end
    chk(ale_cnt == 3, "R2 latch width", ale_cnt, 3);
    chk(!ale_bad, "R2 low address", ale_bad, 0);
    chk(!hold_bad, "R3 address hold", hold_bad, 0);
    chk(!ahi_bad, "R6 high address", ahi_bad, 0);
    chk(!rd_on_wr && !wr_on_rd, "R8 strobe direction", {rd_on_wr, wr_on_rd}, 0);
    chk(ale_rises == 1 && rdy_cnt == 1, "R9 single cycle", ale_rises * 16 + rdy_cnt, 16'h11);
    chk(!rdy_pos_bad && rdy_cnt == 1, "R10 ready", rdy_cnt, 1);
    if (we) begin
      chk(wr_cnt == 3, "R5 write width", wr_cnt, 3);
      chk(!wdat_bad, "R5 write data", wdat_bad, 0);
      chk(!wrel_bad, "R5 data hold and release", wrel_bad, 0);
    end else begin
      chk(rd_cnt == 3, "R4 read width", rd_cnt, 3);
      chk(!flt_bad, "R3 port floats", flt_bad, 0);
      chk(got == mem_f(a), "R4 read data", got, mem_f(a));
    end
  endtask

  initial begin
    rst_n = 1'b0; ext_fetch_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_fetch = 1'b0; req_addr = '0; req_wdata = '0; lat_lo = '0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(bus_ale_n && bus_rd_n && bus_wr_n, "R1 strobes in reset",
        {bus_ale_n, bus_rd_n, bus_wr_n}, 7);
    chk(!bus_ad_oe && !rsp_ready, "R1 port and ready in reset", {bus_ad_oe, rsp_ready}, 0);
    chk(bus_ahi == 8'h00, "R1 boot high address", bus_ahi, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 idle after reset
    chk(bus_ale_n && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_ready,
        "R1 idle after reset", {bus_ale_n, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_ready}, 5'h1C);
    // sweep of data reads and writes over spread addresses
    for (int i = 0; i < 32; i++) begin
      run_cycle(1'b0, 1'b0, i[0], 16'((i * 37) << 8 | ((i * 11) & 255)), 8'h00, 1'b1, 1'b0);
      run_cycle(1'b1, i[1], i[0], 16'(((255 - i * 5) & 255) << 8 | ((i * 29) & 255)),
                8'(i * 53 + 1), 1'b1, 1'b0);
    end
    // R7: fetches routed external versus internal
    for (int i = 0; i < 4; i++) begin
      run_cycle(1'b0, 1'b1, 1'b0, 16'h0040 + 16'(i * 257), 8'h00, 1'b1, 1'b0);
      run_cycle(1'b0, 1'b1, 1'b1, 16'h1234 + 16'(i * 257), 8'h00, 1'b0, 1'b0);
    end
    // R9: request raised in the middle of a cycle
    run_cycle(1'b0, 1'b0, 1'b0, 16'hA55A, 8'h00, 1'b1, 1'b1);
    run_cycle(1'b1, 1'b0, 1'b0, 16'h3CC3, 8'h96, 1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule